// File: doc/BRIEF.md
# Low-Power Sleep Mode Controller

This block picks the low-power state a processor core enters when a sleep instruction retires, and brings the core back to the running state when an interrupt arrives. Two configuration bits, each taken from a standby-control register, are sampled at the moment of the sleep request. Together they pick one of three sleep depths. Each depth gates a different set of units: the core clock alone, the core clock plus the DMA engine, or everything including the timer and serial peripherals.

Before the timer and serial clocks stop in the deepest state, the controller keeps them running for a programmable number of cycles so that those peripherals can finish their pending work. An interrupt pending in any sleep state returns the controller to running in one cycle. All outputs are decoded from registered state, so they are glitch-free and can drive clock-gating cells directly. The interface consists of plain control and status pins. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset, `pwr_state` is RUNNING (code 0), `core_clk_en` is 1, `periph_clk_en` is 1 and `dma_halt` is 0.
- R2: When `sleep_req` is 1 in RUNNING with no interrupt pending and `stby_bit` is 1, the next state is STANDBY (code 3). This holds whatever the value of `deep_bit`.
- R3: When `sleep_req` is 1 in RUNNING with no interrupt pending, `stby_bit` is 0 and `deep_bit` is 1, the next state is DEEP_SLEEP (code 2).
- R4: When `sleep_req` is 1 in RUNNING with no interrupt pending and both select bits are 0, the next state is SLEEP (code 1).
- R5: `core_clk_en` is 0 in every state other than RUNNING and 1 in RUNNING.
- R6: `dma_halt` is 1 in DEEP_SLEEP and STANDBY and 0 in RUNNING and SLEEP. `periph_clk_en` is 1 in every state other than STANDBY.
- R7: On entry to STANDBY, `periph_clk_en` stays 1 for exactly SETTLE_CYC cycles, then stays 0 until the state is left. Every new entry restarts this window.
- R8: An interrupt pending in SLEEP, DEEP_SLEEP or STANDBY moves the state to RUNNING on the next cycle, with all outputs at their RUNNING values.
- R9: A `sleep_req` that arrives while the controller is in a sleep state, with no interrupt pending, leaves the state and outputs unchanged.
- R10: When `sleep_req` and `irq_pending` are both 1 in RUNNING, the controller stays in RUNNING.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Pulse from a retired sleep instruction |
| stby_bit | input | 1 | Standby select bit from the first standby-control register |
| deep_bit | input | 1 | Deep-sleep select bit from the second standby-control register |
| irq_pending | input | 1 | An interrupt is pending |
| pwr_state | output | 2 | Current state: 0 RUNNING, 1 SLEEP, 2 DEEP_SLEEP, 3 STANDBY |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Timer and serial peripheral clock enable |
| dma_halt | output | 1 | Halt request to the DMA controller |

## Verification
The bench builds the block with SETTLE_CYC set to 3. With this value the peripheral clock stays high for several cycles after entering STANDBY and then drops, so the exact cycle at which it falls can be observed. A wake-up can also be injected in the middle of that window, and a following re-entry then shows whether the window restarts in full. The selection priority and the same-cycle interrupt race are each driven as their own directed scenario.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    PS_RUN   = 2'd0,
    PS_LIGHT = 2'd1,
    PS_DEEP  = 2'd2,
    PS_STBY  = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pwr_sleep_select.sv
module pwr_sleep_select
  import pwr_sleep_pkg::*;
(
  input  logic       stby_bit,
  input  logic       deep_bit,
  output pwr_state_e target
);
  // Standby has priority over deep sleep; neither gives light sleep.
  always_comb begin
    if (stby_bit)      target = PS_STBY;
    else if (deep_bit) target = PS_DEEP;
    else               target = PS_LIGHT;
  end
endmodule

// File: rtl/pwr_sleep_fsm.sv
module pwr_sleep_fsm
  import pwr_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_req,
  input  logic       irq_pending,
  input  pwr_state_e target,
  output pwr_state_e state,
  output logic       enter_stby
);
  pwr_state_e nxt;

  always_comb begin
    nxt = state;
    if (state == PS_RUN) begin
      // A pending interrupt cancels a request in the same cycle.
      if (sleep_req && !irq_pending) nxt = target;
    end else if (irq_pending) begin
      nxt = PS_RUN;
    end
  end

  assign enter_stby = (nxt == PS_STBY) && (state != PS_STBY);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= PS_RUN;
    else        state <= nxt;
  end
endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic in_stby,
  output logic settling
);
  generate
    if (SETTLE_CYC == 0) begin : g_none
      assign settling = 1'b0;
    end else begin : g_count
      localparam int CNT_W = $clog2(SETTLE_CYC + 1);
      localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(SETTLE_CYC);
      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (load)                    cnt <= LOAD_V;
        else if (!in_stby)                cnt <= '0;
        else if (cnt != '0)               cnt <= cnt - 1'b1;
      end

      assign settling = (cnt != '0);
    end
  endgenerate
endmodule

// File: rtl/pwr_out_map.sv
module pwr_out_map
  import pwr_sleep_pkg::*;
(
  input  pwr_state_e state,
  input  logic       settling,
  output logic       core_clk_en,
  output logic       periph_clk_en,
  output logic       dma_halt
);
  always_comb begin
    core_clk_en   = (state == PS_RUN);
    dma_halt      = (state == PS_DEEP) || (state == PS_STBY);
    periph_clk_en = (state != PS_STBY) || settling;
  end
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_sleep_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sleep_req,
  input  logic               stby_bit,
  input  logic               deep_bit,
  input  logic               irq_pending,
  output logic [STATE_W-1:0] pwr_state,
  output logic               core_clk_en,
  output logic               periph_clk_en,
  output logic               dma_halt
);
  pwr_state_e target;
  pwr_state_e state;
  logic       enter_stby;
  logic       settling;

  pwr_sleep_select u_sel (
    .stby_bit (stby_bit),
    .deep_bit (deep_bit),
    .target   (target)
  );

  pwr_sleep_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_req   (sleep_req),
    .irq_pending (irq_pending),
    .target      (target),
    .state       (state),
    .enter_stby  (enter_stby)
  );

  pwr_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (enter_stby),
    .in_stby  (state == PS_STBY),
    .settling (settling)
  );

  pwr_out_map u_map (
    .state         (state),
    .settling      (settling),
    .core_clk_en   (core_clk_en),
    .periph_clk_en (periph_clk_en),
    .dma_halt      (dma_halt)
  );

  assign pwr_state = state;
endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
module pwr_sleep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_req,
  input logic       stby_bit,
  input logic       deep_bit,
  input logic       irq_pending,
  input logic [1:0] pwr_state,
  input logic       core_clk_en,
  input logic       periph_clk_en,
  input logic       dma_halt
);
  AST_STBY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0 && sleep_req && !irq_pending && stby_bit) |=> pwr_state == 2'd3); // R2
  AST_DEEP_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0 && sleep_req && !irq_pending && !stby_bit && deep_bit) |=> pwr_state == 2'd2); // R3
  AST_LIGHT_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0 && sleep_req && !irq_pending && !stby_bit && !deep_bit) |=> pwr_state == 2'd1); // R4
  AST_CORE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 2'd0) |-> !core_clk_en); // R5
  AST_DMA_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state[1]) |-> dma_halt); // R6
  AST_PERIPH_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 2'd3) |-> periph_clk_en); // R6
  AST_IRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 2'd0 && irq_pending) |=> (pwr_state == 2'd0 && core_clk_en)); // R8
  AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 2'd0 && !irq_pending) |=> $stable(pwr_state)); // R9
  AST_IRQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0 && irq_pending) |=> pwr_state == 2'd0); // R10
endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sleep_req     (sleep_req),
  .stby_bit      (stby_bit),
  .deep_bit      (deep_bit),
  .irq_pending   (irq_pending),
  .pwr_state     (pwr_state),
  .core_clk_en   (core_clk_en),
  .periph_clk_en (periph_clk_en),
  .dma_halt      (dma_halt)
);

// File: tb/pwr_sleep_ctrl_test.sv
`timescale 1ns/1ps
module pwr_sleep_ctrl_test;
  localparam int SETTLE = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, stby_bit = 1'b0, deep_bit = 1'b0, irq_pending = 1'b0;
  logic [1:0] pwr_state;
  logic core_clk_en, periph_clk_en, dma_halt;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_sleep_ctrl #(.SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .stby_bit(stby_bit),
    .deep_bit(deep_bit), .irq_pending(irq_pending), .pwr_state(pwr_state),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .dma_halt(dma_halt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Expected outputs derived from the state code.
  task automatic check_outs(input string req, input int st, input int per);
    check({req, " state"}, int'(pwr_state), st);
    check({req, " core_en"}, int'(core_clk_en), (st == 0) ? 1 : 0);
    check({req, " dma_halt"}, int'(dma_halt), (st >= 2) ? 1 : 0);
    check({req, " periph_en"}, int'(periph_clk_en), per);
  endtask

  task automatic request(input logic s, input logic d);
    stby_bit = s; deep_bit = d; sleep_req = 1'b1;
    step();
    sleep_req = 1'b0; stby_bit = 1'b0; deep_bit = 1'b0;
  endtask

  task automatic wake(input string req);
    irq_pending = 1'b1;
    step();
    irq_pending = 1'b0;
    check_outs(req, 0, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    check_outs("R1 reset", 0, 1);
    rst_n = 1'b1;
    step();
    check_outs("R1 after release", 0, 1);
  endtask

  task automatic t_standby();
    request(1'b1, 1'b1);
    for (int i = 0; i < SETTLE; i++) begin
      check_outs("R2 R7 standby settling", 3, 1);
      step();
    end
    check_outs("R7 standby settled", 3, 0);
    step();
    check_outs("R7 standby held", 3, 0);
    wake("R8 wake from standby");
  endtask

  task automatic t_deep();
    request(1'b0, 1'b1);
    check_outs("R3 R5 R6 deep sleep", 2, 1);
    step();
    check_outs("R6 deep sleep held", 2, 1);
    wake("R8 wake from deep");
  endtask

  task automatic t_light();
    request(1'b0, 1'b0);
    check_outs("R4 R5 R6 light sleep", 1, 1);
    wake("R8 wake from light");
  endtask

  task automatic t_ignore();
    request(1'b0, 1'b0);
    check_outs("R9 entered light", 1, 1);
    request(1'b1, 1'b1);
    check_outs("R9 request ignored", 1, 1);
    step();
    check_outs("R9 still light", 1, 1);
    wake("R8 wake after ignore");
  endtask

  task automatic t_irq_wins();
    irq_pending = 1'b1;
    request(1'b1, 1'b0);
    irq_pending = 1'b0;
    check_outs("R10 irq beats request", 0, 1);
    step();
    check_outs("R10 still running", 0, 1);
  endtask

  task automatic t_settle_wake();
    request(1'b1, 1'b0);
    check_outs("R7 first entry", 3, 1);
    step();
    wake("R8 wake mid settle");
    request(1'b1, 1'b0);
    for (int i = 0; i < SETTLE; i++) begin
      check_outs("R7 window restarted", 3, 1);
      step();
    end
    check_outs("R7 restarted window ends", 3, 0);
    wake("R8 final wake");
  endtask

  initial begin
    step();
    t_reset();
    t_light();
    t_deep();
    t_standby();
    t_ignore();
    t_irq_wins();
    t_settle_wake();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule